// File: doc/BRIEF.md
# Audio Sample FIFO and Register Front End

This block sits between a 32-bit processor register bus and the serializer of a stereo serial audio port. It holds a 16-entry transmit queue and a 16-entry receive queue, both reached through one data address: a write there queues a sample for playback, and a read there takes the oldest captured sample. The serializer pulls playback samples and delivers captured samples through a one-cycle strobe handshake. Frame timing, bit clock generation and DMA belong to other blocks.

The block compares each queue's fill level against a programmable trigger level and raises a service request. It records receive overflow and transmit starvation as sticky error flags. The four conditions, each gated by its own mask bit, combine into a single interrupt line. Configuration fields (link enable, bit-clock direction, justification mode, loopback, per-direction disables, clock divider) are held here and driven out to the serializer. A self-clearing procedure (set the soft-reset bit, then clear it) empties both queues and returns every register to its reset value.

Registers sit at word addresses 0 (global control), 1 (format control), 2 (status, read only), 3 (interrupt mask), 4 (interrupt clear, write only, reads zero), 5 (clock divider) and 6 (sample data). The bus is single-cycle: a write takes effect at the clock edge where `cpu_wr` is high, and read data is valid combinationally in the same cycle as `cpu_rd`.

Top module: `audio_fifo_csr`

## Requirements
- R1: After reset, global control reads 0x0, format control reads 0x18 (both direction-disable bits set), interrupt mask reads 0x0, divider reads 0x0, and status reads 0x89 while `ser_busy` is low.
- R2: A write to address 6 queues the sample in the transmit FIFO, and a write while 16 samples are queued is dropped. Each `ser_tx_req` cycle takes the oldest queued sample, shown on `tx_sample` in that same cycle.
- R3: A read of address 6 returns the oldest receive sample and removes it, and sixteen reads empty a full receive FIFO in arrival order. A read of an empty receive FIFO returns 0 and changes nothing.
- R4: Status bit 4 (receive service) is 1 while the receive FIFO is non-empty and its level is at or above the global-control field in bits 15:12.
- R5: Status bit 3 (transmit service) is 1 while the transmit FIFO level is at or below the global-control field in bits 11:8.
- R6: A `ser_rx_valid` strobe while the receive FIFO holds 16 samples drops the sample and sets sticky status bit 6 (overrun).
- R7: A `ser_tx_req` strobe while the transmit FIFO is empty sets sticky status bit 5 (underrun), and `tx_sample` is 0 in that cycle.
- R8: Writing a 1 to bit 6 or bit 5 of address 4 clears the overrun or underrun flag; a new error in the same cycle as the clear leaves the flag set.
- R9: `irq` is high exactly when some status bit among 6, 5, 4 and 3 is 1 together with the interrupt-mask bit at the same position.
- R10: While global-control bit 3 (soft reset) is 1, both FIFOs are empty, both error flags are clear and the other registers are held at reset values; a control write with bit 3 set stores only that bit, and clearing it leaves the R1 reset state.
- R11: Status bit 7 reads 1 when link enable (control bit 0) is 0 and `ser_busy` is low; bit 2 follows `ser_busy`; bit 1 is receive-not-empty; bit 0 is transmit-not-full.
- R12: `link_en`, `bclk_out`, `fifo_sel`, `spec_en` follow control bits 0, 2, 5, 4. `loopback`, `play_off`, `rec_off`, `alt_fmt` follow format bits 5, 4, 3, 0. `clk_div` follows the divider register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (pops receive data at address 6) |
| cpu_addr | input | 3 | Register word address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid in the cycle of `cpu_rd` |
| ser_tx_req | input | 1 | Serializer takes one playback sample |
| tx_sample | output | 32 | Oldest playback sample, or 0 when the queue is empty |
| ser_rx_valid | input | 1 | Serializer delivers one captured sample |
| rx_sample | input | 32 | Captured sample |
| ser_busy | input | 1 | Serializer is inside a frame |
| link_en | output | 1 | Link enable |
| bclk_out | output | 1 | Bit clock direction (1 = block drives it) |
| alt_fmt | output | 1 | MSB-justified mode select |
| loopback | output | 1 | Loopback enable |
| play_off | output | 1 | Playback disabled |
| rec_off | output | 1 | Recording disabled |
| fifo_sel | output | 1 | Queue selector for the special function |
| spec_en | output | 1 | Special function enable |
| clk_div | output | 7 | Audio clock divider value |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest state to reach is a collision: an overrun or underrun raised in the very cycle software writes the matching clear bit. The bench drives the interrupt-clear write and an empty-queue `ser_tx_req` on the same clock edge, then reads status to confirm that the set won. Overrun also needs a full receive queue. The bench gets there by pushing exactly sixteen captured samples, adding a seventeenth, and then draining all sixteen reads, which checks that the dropped sample never appears.

// File: rtl/afc_pkg.sv
`timescale 1ns/1ps
package afc_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_FMT   = 3'd1,
        A_STAT  = 3'd2,
        A_IMASK = 3'd3,
        A_ICLR  = 3'd4,
        A_DIV   = 3'd5,
        A_DATA  = 3'd6
    } reg_addr_e;

    // Global control layout; threshold fields are 4 bits wide.
    typedef struct packed {
        logic [3:0] rx_th;     // 15:12
        logic [3:0] tx_th;     // 11:8
        logic [1:0] rsv_hi;    // 7:6
        logic       fifo_sel;  // 5
        logic       spec_en;   // 4
        logic       srst;      // 3
        logic       bclk_dir;  // 2
        logic       rsv_lo;    // 1
        logic       en;        // 0
    } ctrl_t;

    typedef struct packed {
        logic       lpbk;      // 5
        logic       play_dis;  // 4
        logic       rec_dis;   // 3
        logic [1:0] rsv;       // 2:1
        logic       alt;       // 0
    } fmt_t;

    localparam logic [15:0] CTRL_WMASK     = 16'hFF3D;
    localparam logic [15:0] CTRL_SRST_ONLY = 16'h0008;
    localparam logic [5:0]  FMT_WMASK      = 6'h39;
    localparam logic [5:0]  FMT_RST        = 6'h18;
    localparam logic [7:0]  IMASK_WMASK    = 8'h78;

    localparam int ST_OFF  = 7;
    localparam int ST_ORUN = 6;
    localparam int ST_URUN = 5;
    localparam int ST_RSVC = 4;
    localparam int ST_TSVC = 3;
    localparam int ST_BUSY = 2;
    localparam int ST_RNE  = 1;
    localparam int ST_TNF  = 0;

    typedef struct packed {
        logic off;
        logic orun;
        logic urun;
        logic rsvc;
        logic tsvc;
        logic busy;
        logic rne;
        logic tnf;
    } status_t;

    function automatic logic [7:0] irq_sources(input status_t s);
        return {1'b0, s.orun, s.urun, s.rsvc, s.tsvc, 3'b000};
    endfunction

endpackage

// File: rtl/afc_fifo.sv
`timescale 1ns/1ps
module afc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          push,
    input  logic [W-1:0]                  din,
    input  logic                          pop,
    output logic [W-1:0]                  dout,
    output logic [$clog2(DEPTH+1)-1:0]    level,
    output logic                          full,
    output logic                          empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push)
                wptr <= (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_pop)
                rptr <= (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/afc_regs.sv
`timescale 1ns/1ps
module afc_regs
    import afc_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_fmt,
    input  logic              wr_imask,
    input  logic              wr_div,
    input  logic [BUS_W-1:0]  wdata,
    output ctrl_t             ctrl,
    output fmt_t              fmt,
    output logic [7:0]        imask,
    output logic [DIV_W-1:0]  div
);
    logic unused_hi;
    assign unused_hi = ^wdata[BUS_W-1:16];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= ctrl_t'(16'h0000);
        end else if (wr_ctrl) begin
            ctrl <= wdata[3] ? ctrl_t'(CTRL_SRST_ONLY)
                             : ctrl_t'(wdata[15:0] & CTRL_WMASK);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl.srst) begin
            fmt   <= fmt_t'(FMT_RST);
            imask <= '0;
            div   <= '0;
        end else begin
            if (wr_fmt)
                fmt <= fmt_t'(wdata[5:0] & FMT_WMASK);
            if (wr_imask)
                imask <= wdata[7:0] & IMASK_WMASK;
            if (wr_div)
                div <= wdata[DIV_W-1:0];
        end
    end
endmodule

// File: rtl/afc_flags.sv
`timescale 1ns/1ps
module afc_flags
    import afc_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             srst,
    input  logic             clr_orun,
    input  logic             clr_urun,
    input  logic             orun_set,
    input  logic             urun_set,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic             rx_full_n,
    input  logic             rx_empty,
    input  logic             tx_full,
    input  logic [3:0]       rx_th,
    input  logic [3:0]       tx_th,
    input  logic             link_on,
    input  logic             ser_busy,
    input  logic [7:0]       imask,
    output status_t          status,
    output logic             irq
);
    logic orun_q, urun_q;
    logic unused_nf;
    assign unused_nf = rx_full_n;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            orun_q <= 1'b0;
            urun_q <= 1'b0;
        end else begin
            orun_q <= (orun_q && !clr_orun) || orun_set;
            urun_q <= (urun_q && !clr_urun) || urun_set;
        end
    end

    always_comb begin
        status.off  = !link_on && !ser_busy;
        status.orun = orun_q;
        status.urun = urun_q;
        status.rsvc = !rx_empty && (rx_level >= CNT_W'(rx_th));
        status.tsvc = (tx_level <= CNT_W'(tx_th));
        status.busy = ser_busy;
        status.rne  = !rx_empty;
        status.tnf  = !tx_full;
    end

    assign irq = |(irq_sources(status) & imask);
endmodule

// File: rtl/audio_fifo_csr.sv
`timescale 1ns/1ps
module audio_fifo_csr
    import afc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [2:0]        cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    input  logic              ser_tx_req,
    output logic [31:0]       tx_sample,
    input  logic              ser_rx_valid,
    input  logic [31:0]       rx_sample,
    input  logic              ser_busy,
    output logic              link_en,
    output logic              bclk_out,
    output logic              alt_fmt,
    output logic              loopback,
    output logic              play_off,
    output logic              rec_off,
    output logic              fifo_sel,
    output logic              spec_en,
    output logic [DIV_W-1:0]  clk_div,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH+1);

    ctrl_t            ctrl;
    fmt_t             fmt;
    logic [7:0]       imask;
    status_t          status;
    logic             soft_rst;
    logic             wr_ctrl, wr_fmt, wr_imask, wr_div, wr_clr, wr_data, rd_data;
    logic [31:0]      tx_dout, rx_dout;
    logic [CNT_W-1:0] tx_level, rx_level;
    logic             tx_full, tx_empty, rx_full, rx_empty;

    assign wr_ctrl  = cpu_wr && (cpu_addr == A_CTRL);
    assign wr_fmt   = cpu_wr && (cpu_addr == A_FMT);
    assign wr_imask = cpu_wr && (cpu_addr == A_IMASK);
    assign wr_clr   = cpu_wr && (cpu_addr == A_ICLR);
    assign wr_div   = cpu_wr && (cpu_addr == A_DIV);
    assign wr_data  = cpu_wr && (cpu_addr == A_DATA);
    assign rd_data  = cpu_rd && (cpu_addr == A_DATA);
    assign soft_rst = ctrl.srst;

    afc_regs #(.DIV_W(DIV_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .wr_fmt   (wr_fmt),
        .wr_imask (wr_imask),
        .wr_div   (wr_div),
        .wdata    (cpu_wdata),
        .ctrl     (ctrl),
        .fmt      (fmt),
        .imask    (imask),
        .div      (clk_div)
    );

    afc_fifo #(.W(32), .DEPTH(DEPTH)) txq_i (
        .clk   (clk),
        .rst   (rst),
        .flush (soft_rst),
        .push  (wr_data),
        .din   (cpu_wdata),
        .pop   (ser_tx_req),
        .dout  (tx_dout),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    afc_fifo #(.W(32), .DEPTH(DEPTH)) rxq_i (
        .clk   (clk),
        .rst   (rst),
        .flush (soft_rst),
        .push  (ser_rx_valid),
        .din   (rx_sample),
        .pop   (rd_data),
        .dout  (rx_dout),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    afc_flags #(.CNT_W(CNT_W)) flags_i (
        .clk       (clk),
        .rst       (rst),
        .srst      (soft_rst),
        .clr_orun  (wr_clr && cpu_wdata[ST_ORUN]),
        .clr_urun  (wr_clr && cpu_wdata[ST_URUN]),
        .orun_set  (ser_rx_valid && rx_full),
        .urun_set  (ser_tx_req && tx_empty),
        .rx_level  (rx_level),
        .tx_level  (tx_level),
        .rx_full_n (!rx_full),
        .rx_empty  (rx_empty),
        .tx_full   (tx_full),
        .rx_th     (ctrl.rx_th),
        .tx_th     (ctrl.tx_th),
        .link_on   (ctrl.en),
        .ser_busy  (ser_busy),
        .imask     (imask),
        .status    (status),
        .irq       (irq)
    );

    assign tx_sample = tx_empty ? 32'h0 : tx_dout;

    always_comb begin
        case (cpu_addr)
            A_CTRL:  cpu_rdata = {16'h0, ctrl};
            A_FMT:   cpu_rdata = {26'h0, fmt};
            A_STAT:  cpu_rdata = {24'h0, status};
            A_IMASK: cpu_rdata = {24'h0, imask};
            A_DIV:   cpu_rdata = 32'(clk_div);
            A_DATA:  cpu_rdata = rx_empty ? 32'h0 : rx_dout;
            default: cpu_rdata = 32'h0;
        endcase
    end

    assign link_en  = ctrl.en;
    assign bclk_out = ctrl.bclk_dir;
    assign fifo_sel = ctrl.fifo_sel;
    assign spec_en  = ctrl.spec_en;
    assign alt_fmt  = fmt.alt;
    assign loopback = fmt.lpbk;
    assign play_off = fmt.play_dis;
    assign rec_off  = fmt.rec_dis;
endmodule

// File: rtl/afc_chk.sv
`timescale 1ns/1ps
module afc_chk
    import afc_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       soft_rst,
    input logic                       cpu_rd,
    input logic [2:0]                 cpu_addr,
    input logic                       ser_tx_req,
    input logic                       ser_rx_valid,
    input logic                       tx_empty,
    input logic                       rx_empty,
    input logic                       rx_full,
    input logic                       orun,
    input logic                       urun,
    input logic [$clog2(DEPTH+1)-1:0] tx_level,
    input logic [$clog2(DEPTH+1)-1:0] rx_level,
    input logic [7:0]                 imask,
    input logic                       irq
);
    localparam int CNT_W = $clog2(DEPTH+1);

    p_orun_set_r6: assert property (@(posedge clk) disable iff (rst || soft_rst)
        ser_rx_valid && rx_full |=> orun);

    p_urun_set_r7: assert property (@(posedge clk) disable iff (rst || soft_rst)
        ser_tx_req && tx_empty |=> urun);

    p_flush_r10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (tx_level == '0) && (rx_level == '0) && !orun && !urun);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_level <= CNT_W'(DEPTH)) && (rx_level <= CNT_W'(DEPTH)));

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (imask[6:3] == 4'h0) |-> !irq);

    p_empty_read_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_rd && (cpu_addr == A_DATA) && rx_empty && !ser_rx_valid |=> (rx_level == '0));
endmodule

bind audio_fifo_csr afc_chk #(.DEPTH(DEPTH)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .soft_rst     (soft_rst),
    .cpu_rd       (cpu_rd),
    .cpu_addr     (cpu_addr),
    .ser_tx_req   (ser_tx_req),
    .ser_rx_valid (ser_rx_valid),
    .tx_empty     (tx_empty),
    .rx_empty     (rx_empty),
    .rx_full      (rx_full),
    .orun         (status.orun),
    .urun         (status.urun),
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .imask        (imask),
    .irq          (irq)
);

// File: tb/audio_fifo_csr_tb_top.sv
`timescale 1ns/1ps
module audio_fifo_csr_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0, cpu_rdata;
    logic        ser_tx_req = 1'b0, ser_rx_valid = 1'b0, ser_busy = 1'b0;
    logic [31:0] tx_sample, rx_sample = '0;
    logic        link_en, bclk_out, alt_fmt, loopback, play_off, rec_off, fifo_sel, spec_en, irq;
    logic [6:0]  clk_div;
    int          total = 0, bad = 0;

    always #2 clk = ~clk;

    audio_fifo_csr dut_i (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ser_tx_req(ser_tx_req),
        .tx_sample(tx_sample), .ser_rx_valid(ser_rx_valid), .rx_sample(rx_sample),
        .ser_busy(ser_busy), .link_en(link_en), .bclk_out(bclk_out), .alt_fmt(alt_fmt),
        .loopback(loopback), .play_off(play_off), .rec_off(rec_off), .fifo_sel(fifo_sel),
        .spec_en(spec_en), .clk_div(clk_div), .irq(irq)
    );

    localparam logic [2:0] CTRL = 3'd0, FMT = 3'd1, STAT = 3'd2, IMSK = 3'd3,
                           ICLR = 3'd4, DIV = 3'd5, DATA = 3'd6;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic ser_pull(output logic [31:0] d);
        @(negedge clk);
        ser_tx_req = 1'b1;
        #1 d = tx_sample;
        @(negedge clk);
        ser_tx_req = 1'b0;
    endtask

    task automatic ser_push(input logic [31:0] d);
        @(negedge clk);
        ser_rx_valid = 1'b1; rx_sample = d;
        @(negedge clk);
        ser_rx_valid = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl", CTRL, 32'h0);
        expect_reg("R1 fmt", FMT, 32'h18);
        expect_reg("R1 imask", IMSK, 32'h0);
        expect_reg("R1 div", DIV, 32'h0);
        expect_reg("R1 status", STAT, 32'h89);
        check("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_tx_path();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) bus_wr(DATA, 32'hA000_0000 + i);
        bus_wr(DATA, 32'hFFFF_FFFF);
        expect_reg("R2/R11 status full tx", STAT, 32'h80);
        for (int i = 0; i < 16; i++) begin
            ser_pull(v);
            check("R2 tx order", v, 32'hA000_0000 + i);
        end
        expect_reg("R2 tx drained, overflow write dropped", STAT, 32'h89);
    endtask

    task automatic t_rx_path();
        logic [31:0] v;
        bus_wr(CTRL, 32'h4000);
        expect_reg("R4 rx threshold readback", CTRL, 32'h4000);
        for (int i = 0; i < 3; i++) ser_push(32'hB000_0000 + i);
        expect_reg("R4 below threshold", STAT, 32'h8B);
        ser_push(32'hB000_0003);
        expect_reg("R4 at threshold", STAT, 32'h9B);
        for (int i = 4; i < 16; i++) ser_push(32'hB000_0000 + i);
        for (int i = 0; i < 16; i++) begin
            bus_rd(DATA, v);
            check("R3 rx order", v, 32'hB000_0000 + i);
        end
        bus_rd(DATA, v);
        check("R3 empty read returns zero", v, 32'h0);
        expect_reg("R3 empty read keeps state", STAT, 32'h89);
        bus_wr(CTRL, 32'h0);
    endtask

    task automatic t_tx_threshold();
        logic [31:0] v;
        bus_wr(CTRL, 32'h0200);
        for (int i = 0; i < 3; i++) bus_wr(DATA, 32'hC0 + i);
        expect_reg("R5 above tx threshold", STAT, 32'h81);
        ser_pull(v);
        check("R5 pulled sample", v, 32'hC0);
        expect_reg("R5 at tx threshold", STAT, 32'h89);
        ser_pull(v);
        ser_pull(v);
        check("R5 last sample", v, 32'hC2);
        bus_wr(CTRL, 32'h0);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) ser_push(32'hD000_0000 + i);
        ser_push(32'hDEAD_BEEF);
        expect_reg("R6 overrun set", STAT, 32'hDB);
        for (int i = 0; i < 16; i++) begin
            bus_rd(DATA, v);
            check("R6 overrun sample dropped", v, 32'hD000_0000 + i);
        end
        expect_reg("R6 overrun sticky", STAT, 32'hC9);
        ser_pull(v);
        check("R7 underrun sends zero", v, 32'h0);
        expect_reg("R7 underrun set", STAT, 32'hE9);
        bus_wr(ICLR, 32'h40);
        expect_reg("R8 clear overrun only", STAT, 32'hA9);
        bus_wr(ICLR, 32'h20);
        expect_reg("R8 clear underrun", STAT, 32'h89);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = ICLR; cpu_wdata = 32'h20; ser_tx_req = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; ser_tx_req = 1'b0;
        expect_reg("R8 set wins over clear", STAT, 32'hA9);
        bus_wr(ICLR, 32'h60);
        expect_reg("R8 both cleared", STAT, 32'h89);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        bus_wr(IMSK, 32'h08);
        check("R9 tx service irq", {31'h0, irq}, 32'h1);
        bus_wr(IMSK, 32'h10);
        check("R9 rx service masked off while empty", {31'h0, irq}, 32'h0);
        ser_push(32'h55);
        check("R9 rx service irq", {31'h0, irq}, 32'h1);
        bus_rd(DATA, v);
        check("R9 irq drops after read", {31'h0, irq}, 32'h0);
        bus_wr(IMSK, 32'h20);
        ser_pull(v);
        check("R9 underrun irq", {31'h0, irq}, 32'h1);
        bus_wr(ICLR, 32'h20);
        check("R9 irq cleared", {31'h0, irq}, 32'h0);
        bus_wr(IMSK, 32'h0);
    endtask

    task automatic t_soft_reset();
        bus_wr(CTRL, 32'h1);
        bus_wr(FMT, 32'h21);
        bus_wr(IMSK, 32'h78);
        bus_wr(DIV, 32'h0C);
        ser_push(32'h1);
        ser_push(32'h2);
        for (int i = 0; i < 3; i++) bus_wr(DATA, 32'h7 + i);
        check("R10 irq before soft reset", {31'h0, irq}, 32'h1);
        bus_wr(CTRL, 32'hF009);
        expect_reg("R10 ctrl holds only reset bit", CTRL, 32'h8);
        expect_reg("R10 status during reset", STAT, 32'h89);
        expect_reg("R10 fmt held", FMT, 32'h18);
        bus_wr(CTRL, 32'h0);
        expect_reg("R10 fmt after", FMT, 32'h18);
        expect_reg("R10 imask after", IMSK, 32'h0);
        expect_reg("R10 div after", DIV, 32'h0);
        expect_reg("R10 status after", STAT, 32'h89);
        check("R10 irq after", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_status_cfg();
        bus_wr(CTRL, 32'h35);
        check("R12 link/bclk/sel/spec", {28'h0, link_en, bclk_out, fifo_sel, spec_en}, 32'hF);
        expect_reg("R11 link on, idle", STAT, 32'h09);
        @(negedge clk) ser_busy = 1'b1;
        expect_reg("R11 busy", STAT, 32'h0D);
        bus_wr(CTRL, 32'h0);
        expect_reg("R11 disabled but busy", STAT, 32'h0D);
        @(negedge clk) ser_busy = 1'b0;
        expect_reg("R11 off", STAT, 32'h89);
        check("R12 fmt defaults", {28'h0, loopback, play_off, rec_off, alt_fmt}, 32'h6);
        bus_wr(FMT, 32'h21);
        check("R12 fmt fields", {28'h0, loopback, play_off, rec_off, alt_fmt}, 32'h9);
        bus_wr(DIV, 32'h30);
        check("R12 divider", {25'h0, clk_div}, 32'h30);
        bus_wr(FMT, 32'h18);
        bus_wr(DIV, 32'h0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_tx_path();
        t_rx_path();
        t_tx_threshold();
        t_errors();
        t_irq();
        t_soft_reset();
        t_status_cfg();
        summary();
        $finish;
    end
endmodule